// File: doc/BRIEF.md
# Segment Display Mode Engine

This block sits between the double-buffered pixel store of a segment display and the waveform generator. Software writes pixel states into a user buffer through a masked write port. At every frame start the user buffer is copied into a display buffer, unless the copy is suppressed. The block then applies one of eight display modes to produce the pixel states that the waveform generator drives for that frame. None of the modes alters either buffer.

The mode code and the blink-rate code are inputs. Both are sampled only at a frame start, so every frame is drawn in a single mode. A blink divider counts frame-end pulses and toggles a blink phase. The blinking modes and the buffer-alternation mode follow that phase. The pixel output is registered and follows the engine's state with one cycle of latency.

Top module: `seg_mode_engine`

## Requirements
- R1: After a synchronous active-low reset, the pixel output, both buffers, the active mode (pass-through), the blink code and the blink phase are all zero.
- R2: A write with `usr_wr_en` high replaces only the user-buffer bits whose `usr_wr_mask` bit is 1, taking those bits from `usr_wr_data`.
- R3: On `frame_start`, the display buffer loads the user buffer as it stood before that edge. When the incoming mode code is 6 (load-blocked), the display buffer keeps its value. At no other time does the display buffer change.
- R4: `mode_sel` and `blink_sel` are taken into the active mode and the active blink code only on `frame_start`. Changes to them at any other time have no effect on the output.
- R5: Mode 0 (pass-through) and mode 6 (load-blocked) show the display buffer unchanged.
- R6: Mode 1 shows all pixels as 0 and mode 2 shows all pixels as 1.
- R7: Mode 3 shows the display buffer while the blink phase is 0 and all zeros while it is 1.
- R8: Mode 4 shows the bitwise inverse of the display buffer.
- R9: Mode 5 shows the inverse of the display buffer while the blink phase is 0 and all zeros while it is 1.
- R10: Mode 7 shows the user buffer while the blink phase is 0 and the display buffer while it is 1.
- R11: The blink phase toggles on the (N+1)-th `frame_end` pulse counted since its last toggle, where N is the active blink code. With N = 0 it toggles on every frame end. N is the value latched before the same edge.
- R12: `pix_out` is registered: at each clock edge it takes the value selected by the active mode, the buffers and the blink phase as they stood just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that opens a frame |
| frame_end | input | 1 | One-cycle pulse that closes a frame |
| usr_wr_en | input | 1 | User-buffer write strobe |
| usr_wr_mask | input | NUM_PIX | Per-pixel write enable |
| usr_wr_data | input | NUM_PIX | Pixel states to write |
| mode_sel | input | 3 | Requested display mode code |
| blink_sel | input | BLINK_W | Requested blink code N |
| pix_out | output | NUM_PIX | Pixel states for the waveform generator |
| blink_phase | output | 1 | Current blink phase |

## Verification
Directed sequences put distinct, asymmetric patterns such as 0xA5C3 into the two buffers. With these patterns, pass-through, inversion and buffer alternation each give a visibly different result. A mode change in mid-frame shows whether the mode latch waits for a frame start. A load-blocked frame followed by a user write shows whether the copy was really suppressed. Blink codes of 0 and 2 separate a divider that counts N+1 frame ends from one that counts N. Random traffic from a fixed seed then mixes masked writes, mode and blink-code changes, and pulses that coincide with writes and with each other. Each cycle's output is compared with the value a bench model derives from the requirements.

// File: rtl/seg_mode_pkg.sv
// Shared types for the segment display mode engine.
// Assumes: mode codes are fixed by the software-visible encoding.
package seg_mode_pkg;

    typedef enum logic [2:0] {
        DM_PASS     = 3'd0,
        DM_OFF      = 3'd1,
        DM_ON       = 3'd2,
        DM_BLINK    = 3'd3,
        DM_INV      = 3'd4,
        DM_INVBLINK = 3'd5,
        DM_HOLD     = 3'd6,
        DM_SWAP     = 3'd7
    } disp_mode_e;

endpackage

// File: rtl/seg_buf_store.sv
// User and display pixel buffers.
// The user buffer takes masked writes at any cycle. The display buffer
// loads the pre-edge user buffer on a frame start unless the copy is blocked.
// Assumes: frame_start is a single-cycle pulse.
module seg_buf_store #(
    parameter int NUM_PIX = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               copy_block,
    input  logic               wr_en,
    input  logic [NUM_PIX-1:0] wr_mask,
    input  logic [NUM_PIX-1:0] wr_data,
    output logic [NUM_PIX-1:0] usr_buf,
    output logic [NUM_PIX-1:0] disp_buf
);

    // Masked write into the user buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            usr_buf <= '0;
        else if (wr_en)
            usr_buf <= (usr_buf & ~wr_mask) | (wr_data & wr_mask);
    end

    // Frame-start transfer from the user buffer to the display buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            disp_buf <= '0;
        else if (frame_start && !copy_block)
            disp_buf <= usr_buf;
    end

    AST_DISP_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(disp_buf)); // R3
    AST_DISP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && copy_block) |=> $stable(disp_buf)); // R3
    AST_USR_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(usr_buf)); // R2

endmodule

// File: rtl/seg_blink_div.sv
// Blink-rate divider. It counts frame-end pulses and toggles the blink
// phase on the (N+1)-th one, where N is the active blink code.
// Assumes: a code lowered below the running count wraps at the next frame end.
module seg_blink_div #(
    parameter int BLINK_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_end,
    input  logic [BLINK_W-1:0] blink_lim,
    output logic               phase
);

    logic [BLINK_W-1:0] fe_cnt;

    // Frame-end counter and phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fe_cnt <= '0;
            phase  <= 1'b0;
        end else if (frame_end) begin
            if (fe_cnt >= blink_lim) begin
                fe_cnt <= '0;
                phase  <= ~phase;
            end else begin
                fe_cnt <= fe_cnt + 1'b1;
            end
        end
    end

    AST_PHASE_ON_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(phase)); // R11
    AST_FAST_BLINK: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && blink_lim == '0) |=> (phase != $past(phase))); // R11

endmodule

// File: rtl/seg_pix_sel.sv
// Per-frame pixel selection. It applies the active display mode to the
// buffers and the blink phase, and registers the result.
// Assumes: the mode is held stable across a frame by the caller.
module seg_pix_sel #(
    parameter int NUM_PIX = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  seg_mode_pkg::disp_mode_e mode,
    input  logic                     phase,
    input  logic [NUM_PIX-1:0]       usr_buf,
    input  logic [NUM_PIX-1:0]       disp_buf,
    output logic [NUM_PIX-1:0]       pix_q
);
    import seg_mode_pkg::*;

    logic [NUM_PIX-1:0] pix_d;

    // Mode decode of the next pixel vector.
    always_comb begin
        unique case (mode)
            DM_PASS, DM_HOLD: pix_d = disp_buf;
            DM_OFF:           pix_d = '0;
            DM_ON:            pix_d = '1;
            DM_BLINK:         pix_d = phase ? '0 : disp_buf;
            DM_INV:           pix_d = ~disp_buf;
            DM_INVBLINK:      pix_d = phase ? '0 : ~disp_buf;
            DM_SWAP:          pix_d = phase ? disp_buf : usr_buf;
            default:          pix_d = disp_buf;
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pix_q <= '0;
        else
            pix_q <= pix_d;
    end

    AST_INV_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DM_INV) |=> (pix_q == ~$past(disp_buf))); // R8
    AST_SWAP_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DM_SWAP && !phase) |=> (pix_q == $past(usr_buf))); // R10

endmodule

// File: rtl/seg_mode_engine.sv
// Segment display mode engine (top). It latches the mode and blink codes
// at frame start, and ties together the buffers, the blink divider and the
// pixel selector.
// Assumes: frame_start and frame_end are single-cycle pulses in clk.
module seg_mode_engine #(
    parameter int NUM_PIX = 16,
    parameter int BLINK_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               frame_end,
    input  logic               usr_wr_en,
    input  logic [NUM_PIX-1:0] usr_wr_mask,
    input  logic [NUM_PIX-1:0] usr_wr_data,
    input  logic [2:0]         mode_sel,
    input  logic [BLINK_W-1:0] blink_sel,
    output logic [NUM_PIX-1:0] pix_out,
    output logic               blink_phase
);
    import seg_mode_pkg::*;

    disp_mode_e         act_mode;
    logic [BLINK_W-1:0] act_blink;
    logic [NUM_PIX-1:0] usr_buf;
    logic [NUM_PIX-1:0] disp_buf;
    logic               copy_block;

    assign copy_block = (disp_mode_e'(mode_sel) == DM_HOLD);

    // Frame-start latch of the mode and blink codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mode  <= DM_PASS;
            act_blink <= '0;
        end else if (frame_start) begin
            act_mode  <= disp_mode_e'(mode_sel);
            act_blink <= blink_sel;
        end
    end

    seg_buf_store #(.NUM_PIX(NUM_PIX)) u_bufs (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .copy_block  (copy_block),
        .wr_en       (usr_wr_en),
        .wr_mask     (usr_wr_mask),
        .wr_data     (usr_wr_data),
        .usr_buf     (usr_buf),
        .disp_buf    (disp_buf)
    );

    seg_blink_div #(.BLINK_W(BLINK_W)) u_blink (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .blink_lim (act_blink),
        .phase     (blink_phase)
    );

    seg_pix_sel #(.NUM_PIX(NUM_PIX)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (act_mode),
        .phase    (blink_phase),
        .usr_buf  (usr_buf),
        .disp_buf (disp_buf),
        .pix_q    (pix_out)
    );

    AST_MODE_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(act_mode)); // R4
    AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == DM_OFF) |=> (pix_out == '0)); // R6
    AST_FORCE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == DM_ON) |=> (pix_out == '1)); // R6

endmodule

// File: tb/seg_mode_engine_tb.sv
`timescale 1ns/1ps
module seg_mode_engine_tb_top;

    localparam int NP = 16;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          frame_end = 1'b0;
    logic          usr_wr_en = 1'b0;
    logic [NP-1:0] usr_wr_mask = '0;
    logic [NP-1:0] usr_wr_data = '0;
    logic [2:0]    mode_sel = '0;
    logic [BW-1:0] blink_sel = '0;
    logic [NP-1:0] pix_out;
    logic          blink_phase;

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model state
    logic [NP-1:0] m_usr, m_disp;
    logic [2:0]    m_mode;
    logic [BW-1:0] m_blink, m_cnt;
    logic          m_ph;

    always #2.5 clk = ~clk;

    seg_mode_engine #(.NUM_PIX(NP), .BLINK_W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
        .usr_wr_en(usr_wr_en), .usr_wr_mask(usr_wr_mask), .usr_wr_data(usr_wr_data),
        .mode_sel(mode_sel), .blink_sel(blink_sel),
        .pix_out(pix_out), .blink_phase(blink_phase)
    );

    function automatic logic [NP-1:0] exp_pix(input logic [2:0] md, input logic ph,
                                              input logic [NP-1:0] u, input logic [NP-1:0] d);
        case (md)
            3'd1:    return '0;
            3'd2:    return '1;
            3'd3:    return ph ? '0 : d;
            3'd4:    return ~d;
            3'd5:    return ph ? '0 : ~d;
            3'd7:    return ph ? d : u;
            default: return d;
        endcase
    endfunction

    function automatic string mode_tag(input logic [2:0] md);
        case (md)
            3'd1, 3'd2: return "R6";
            3'd3:       return "R7";
            3'd4:       return "R8";
            3'd5:       return "R9";
            3'd7:       return "R10";
            default:    return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_usr = '0; m_disp = '0; m_mode = '0; m_blink = '0; m_cnt = '0; m_ph = 1'b0;
    endtask

    // One clock: drive at negedge, model the edge, compare just after it.
    task automatic step(input logic fs, input logic fe, input logic we,
                        input logic [NP-1:0] msk, input logic [NP-1:0] dat,
                        input logic [2:0] md, input logic [BW-1:0] bl, input string extra);
        logic [NP-1:0] e;
        logic [NP-1:0] old_usr;
        @(negedge clk);
        frame_start = fs; frame_end = fe; usr_wr_en = we;
        usr_wr_mask = msk; usr_wr_data = dat; mode_sel = md; blink_sel = bl;
        @(posedge clk);
        e = exp_pix(m_mode, m_ph, m_usr, m_disp);   // R12: value from pre-edge state
        old_usr = m_usr;
        if (fe) begin                                // R11
            if (m_cnt >= m_blink) begin m_cnt = '0; m_ph = ~m_ph; end
            else m_cnt = m_cnt + 1'b1;
        end
        if (fs) begin                                // R3, R4
            if (md != 3'd6) m_disp = old_usr;
            m_mode = md; m_blink = bl;
        end
        if (we) m_usr = (m_usr & ~msk) | (dat & msk); // R2
        #1;
        check({extra, mode_tag(m_mode)}, pix_out, e);
        check("R11 phase", {{(NP-1){1'b0}}, blink_phase}, {{(NP-1){1'b0}}, m_ph});
    endtask

    // Watchdog
    initial begin
        #(150000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset pix", pix_out, '0);
        check("R1 reset phase", {{(NP-1){1'b0}}, blink_phase}, '0);
        @(negedge clk); rst_n = 1'b1;

        // R2: masked writes; R3/R5: copy then pass-through
        step(0,0,1,16'hFFFF,16'hA5C3,3'd0,8'd0,"R2 ");
        step(0,0,1,16'h00F0,16'h0F0F,3'd0,8'd0,"R2 ");
        step(1,0,0,'0,'0,3'd0,8'd0,"R3 ");
        step(0,0,0,'0,'0,3'd0,8'd0,"R3 ");
        // R4: mode change mid-frame has no effect
        step(0,0,0,'0,'0,3'd4,8'd0,"R4 ");
        step(0,0,0,'0,'0,3'd4,8'd0,"R4 ");
        step(1,0,0,'0,'0,3'd4,8'd0,"R4 ");
        step(0,0,0,'0,'0,3'd4,8'd0,"R8 ");
        // R3: load-blocked frame then user write, then mode 0 shows old display
        step(1,0,1,16'hFFFF,16'h1234,3'd6,8'd0,"R3 ");
        step(0,0,0,'0,'0,3'd6,8'd0,"R3 ");
        step(1,0,0,'0,'0,3'd6,8'd0,"R3 ");
        step(0,0,0,'0,'0,3'd0,8'd0,"R3 ");
        // R10: swap with distinct buffers
        step(1,0,0,'0,'0,3'd7,8'd0,"R10 ");
        step(0,0,1,16'hFFFF,16'h5A5A,3'd7,8'd0,"R10 ");
        step(0,0,0,'0,'0,3'd7,8'd0,"R10 ");
        step(0,1,0,'0,'0,3'd7,8'd0,"R10 ");
        step(0,0,0,'0,'0,3'd7,8'd0,"R10 ");
        // R11: blink code 2, needs three frame ends per toggle; R7 blink
        step(1,0,0,'0,'0,3'd3,8'd2,"R11 ");
        for (int k = 0; k < 8; k++) begin
            step(0,1,0,'0,'0,3'd3,8'd2,"R7 ");
            step(0,0,0,'0,'0,3'd3,8'd2,"R7 ");
        end
        // R9: inverted blink
        step(1,0,0,'0,'0,3'd5,8'd0,"R9 ");
        for (int k = 0; k < 4; k++) step(0,1,0,'0,'0,3'd5,8'd0,"R9 ");
        // R6: forced off / on
        step(1,0,0,'0,'0,3'd1,8'd0,"R6 ");
        step(0,0,0,'0,'0,3'd1,8'd0,"R6 ");
        step(1,0,0,'0,'0,3'd2,8'd0,"R6 ");
        step(0,0,0,'0,'0,3'd2,8'd0,"R6 ");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic fs, fe, we;
            logic [2:0] md;
            logic [BW-1:0] bl;
            fs = ($urandom % 8) == 0;
            fe = ($urandom % 6) == 0;
            we = ($urandom % 4) == 0;
            md = 3'($urandom % 8);
            bl = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 3);
            step(fs, fe, we, 16'($urandom), 16'($urandom), md, bl, "rnd ");
        end

        // Mid-run reset returns to R1 state
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        model_reset();
        check("R1 re-reset pix", pix_out, '0);
        @(negedge clk); rst_n = 1'b1;
        step(0,0,0,'0,'0,3'd0,8'd0,"R1 ");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule